// File: doc/BRIEF.md
# Multi-mode floating-point min/max unit

This block picks the smaller or larger of two 64-bit double-precision operands under a 4-bit mode code. One sign-magnitude comparator serves every mode: the code chooses minimum or maximum, a plain or a magnitude comparison, and one of four rules for what to return when a NaN is involved. These are the 2008-style Num rule, the 2019 propagating rule, the 2019 Number rule, and a plain compare-and-select rule that falls back to the second operand.

Besides the result, the unit reports whether either operand was a signaling NaN. It also drives a write enable that is low when the invalid-operation exception is enabled and a signaling NaN was seen, so that the destination is left untouched. A parameter places a register on the outputs (default) or leaves the unit purely combinational.

Top module: `fp_minmax_unit`

## Requirements
- R1: An operand is a NaN when its bits 62:0, read as unsigned, exceed 0x7FF0_0000_0000_0000. It is signaling when bit 51 (the quiet bit) is 0. `snan_flag` is 1 exactly when at least one operand is signaling.
- R2: A NaN is quieted by setting bit 51 to 1 and keeping every other bit.
- R3: With mode[1:0]=00 and any NaN operand, the first matching rule decides: a signaling gives quieted a; b signaling gives quieted b; both NaN gives quieted a; only a NaN gives b; otherwise a.
- R4: With mode[1:0]=01 and any NaN operand, the result is quieted a when a is a NaN, else quieted b.
- R5: With mode[1:0]=10 and any NaN operand, the result is quieted a when both are NaN, b when only a is a NaN, and a when only b is a NaN.
- R6: With mode[1:0]=11 and any NaN operand, the result is b unchanged.
- R7: With no NaN, mode[3]=0 returns the smaller and mode[3]=1 the larger value, ordered as sign-magnitude numbers with -0 below +0. On a tie b is returned.
- R8: With mode[2]=1 and no NaN, operands are ordered by magnitude (bit 63 ignored). When the magnitudes are equal, the signed order of R7 decides.
- R9: With mode=x111 and no NaN, a zero of either sign counts as +0. A pair of zeros is therefore a tie and returns b.
- R10: `wr_en` is 0 exactly when `inv_en` is 1 and `snan_flag` is 1.
- R11: With OUT_REG=1, outputs appear one clock after the inputs. While rst_n is low, result, snan_flag and wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_a | input | 64 | First operand, bit 63 sign |
| op_b | input | 64 | Second operand, bit 63 sign |
| mode | input | 4 | [3] max, [2] magnitude, [1:0] NaN rule |
| inv_en | input | 1 | Invalid-operation exception enable |
| result | output | 64 | Selected value |
| snan_flag | output | 1 | A signaling NaN was present |
| wr_en | output | 1 | Result may be written |

## Verification
In one cycle the NaN rule, which selects or quiets the returned value, and the exception gating of the write enable can both act. Vectors with a signaling NaN in either position are applied with the exception enable both clear and set. The bench expects the same quieted result in both cases and expects only `wr_en` to change. Every mode is also swept over a grid of zeros, infinities, denormals and both NaN kinds, and each output is compared with a model written from the requirements.

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [3:0]  mode,
  input  logic        inv_en,
  output logic [63:0] result,
  output logic        snan_flag,
  output logic        wr_en
);
  localparam logic [63:0] EXP_ALL1 = 64'h7FF0_0000_0000_0000;
  localparam int          QBIT     = 51;

  logic [63:0] mag_a, mag_b, qa, qb, lhs, rhs, res_c;
  logic        a_nan, b_nan, a_sig, b_sig, any_sig, take_a, wr_c;

  assign mag_a = {1'b0, op_a[62:0]};
  assign mag_b = {1'b0, op_b[62:0]};
  assign a_nan = mag_a > EXP_ALL1;
  assign b_nan = mag_b > EXP_ALL1;
  assign a_sig = a_nan & ~op_a[QBIT];
  assign b_sig = b_nan & ~op_b[QBIT];
  assign any_sig = a_sig | b_sig;
  assign qa = op_a | (64'd1 << QBIT);
  assign qb = op_b | (64'd1 << QBIT);
  assign wr_c = ~inv_en | ~any_sig;

  always_comb begin
    lhs = op_a;
    rhs = op_b;
    if (mode[2] && mag_a != mag_b) begin
      lhs = mag_a;
      rhs = mag_b;
    end
    if (mode[2] && mode[1:0] == 2'b11) begin
      if (mag_a == 64'd0) lhs = 64'd0;
      if (mag_b == 64'd0) rhs = 64'd0;
    end
    if (mode[3]) begin
      lhs = rhs;
      rhs = mode[2] && mag_a != mag_b ? mag_a : op_a;
      if (mode[2] && mode[1:0] == 2'b11 && mag_a == 64'd0) rhs = 64'd0;
    end
    if (lhs[63]) take_a = rhs[63] ? (lhs > rhs) : 1'b1;
    else         take_a = rhs[63] ? 1'b0 : (lhs < rhs);
  end

  always_comb begin
    res_c = take_a ? op_a : op_b;
    if (a_nan || b_nan) begin
      unique case (mode[1:0])
        2'b00: begin
          if (a_sig)               res_c = qa;
          else if (b_sig)          res_c = qb;
          else if (a_nan && b_nan) res_c = qa;
          else if (a_nan)          res_c = op_b;
          else                     res_c = op_a;
        end
        2'b01: res_c = a_nan ? qa : qb;
        2'b10: begin
          if (a_nan && b_nan) res_c = qa;
          else if (a_nan)     res_c = op_b;
          else                res_c = op_a;
        end
        default: res_c = op_b;
      endcase
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          result    <= '0;
          snan_flag <= 1'b0;
          wr_en     <= 1'b0;
          primed    <= 1'b0;
        end else begin
          result    <= res_c;
          snan_flag <= any_sig;
          wr_en     <= wr_c;
          primed    <= 1'b1;
        end
      end

      assert_wr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !wr_en |-> snan_flag && $past(inv_en));

      assert_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !$past(a_nan) && !$past(b_nan) |->
          (result == $past(op_a)) || (result == $past(op_b)));

      assert_csel_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(mode[1:0]) == 2'b11 && $past(a_nan || b_nan) |->
          result == $past(op_b));

      assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(mode[1:0]) == 2'b01 && $past(a_nan || b_nan) |->
          result[QBIT] && result[62:52] == 11'h7FF);

      assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        primed && snan_flag |-> $past(op_a[QBIT] == 1'b0 || op_b[QBIT] == 1'b0));
    end else begin : g_comb
      assign result    = res_c;
      assign snan_flag = any_sig;
      assign wr_en     = wr_c;
    end
  endgenerate
endmodule

// File: tb/fp_minmax_unit_tb_top.sv
module fp_minmax_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  mode = '0;
  logic        inv_en = 1'b0;
  logic [63:0] result;
  logic        snan_flag, wr_en;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  fp_minmax_unit #(.OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .mode(mode),
    .inv_en(inv_en), .result(result), .snan_flag(snan_flag), .wr_en(wr_en));

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, N1 = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P2 = 64'h4000_0000_0000_0000, N2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PI = 64'h7FF0_0000_0000_0000, NI = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000, SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SQ = 64'h7FF8_0000_0000_0001, DN = 64'h0000_0000_0000_0001;
  localparam logic [63:0] ND = 64'h8000_0000_0000_0001;

  typedef struct packed {
    logic [63:0] a, b;
    logic [3:0]  m;
    logic [63:0] exp;
    logic        flag;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{P1, P2, 4'h0, P1, 1'b0, 8'd7},   // R7 min
    '{P1, P2, 4'h8, P2, 1'b0, 8'd7},   // R7 max
    '{NZ, PZ, 4'h0, NZ, 1'b0, 8'd7},   // R7 -0 below +0
    '{NZ, PZ, 4'h8, PZ, 1'b0, 8'd7},
    '{QN, P1, 4'h0, P1, 1'b0, 8'd3},   // R3 only a NaN
    '{P1, SN, 4'h0, SQ, 1'b1, 8'd3},   // R3 b signaling
    '{P1, QN, 4'h1, QN, 1'b0, 8'd4},   // R4
    '{QN, N1, 4'h2, N1, 1'b0, 8'd5},   // R5
    '{QN, P2, 4'h3, P2, 1'b0, 8'd6},   // R6
    '{P1, QN, 4'h3, QN, 1'b0, 8'd6},
    '{N2, P1, 4'h4, P1, 1'b0, 8'd8},   // R8 magnitude min
    '{N2, P1, 4'hC, N2, 1'b0, 8'd8},   // R8 magnitude max
    '{N1, P1, 4'h4, N1, 1'b0, 8'd8},   // R8 equal magnitude
    '{N1, P1, 4'hC, P1, 1'b0, 8'd8},
    '{DN, PZ, 4'h0, PZ, 1'b0, 8'd7},   // R7 denormal
    '{NI, N1, 4'h8, N1, 1'b0, 8'd7},   // R7 negatives
    '{NZ, PZ, 4'h7, PZ, 1'b0, 8'd9},   // R9 zeros tie
    '{SN, P1, 4'h9, SQ, 1'b1, 8'd2}    // R2 quieted a, R4
  };

  function automatic bit is_nan(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 52'd0;
  endfunction
  function automatic bit is_sig(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic logic [63:0] quiet(input logic [63:0] x);
    logic [63:0] y = x;
    y[51] = 1'b1;
    return y;
  endfunction
  // signed order key: larger key = larger value, -0 below +0
  function automatic logic [64:0] key(input logic [63:0] x);
    return x[63] ? {1'b0, ~x} : {1'b1, x};
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, b, input logic [3:0] m);
    logic [64:0] ka, kb;
    logic [62:0] ma, mb;
    bit an = is_nan(a), bn = is_nan(b);
    if (an || bn) begin
      case (m[1:0])
        2'b00: if (is_sig(a)) return quiet(a);
               else if (is_sig(b)) return quiet(b);
               else if (an && bn) return quiet(a);
               else return an ? b : a;
        2'b01: return an ? quiet(a) : quiet(b);
        2'b10: if (an && bn) return quiet(a); else return an ? b : a;
        default: return b;
      endcase
    end
    ka = key(a); kb = key(b);
    ma = a[62:0]; mb = b[62:0];
    if (m[2] && m[1:0] == 2'b11 && ma == 0 && mb == 0) return b;
    if (m[2] && ma != mb) begin
      if (m[3]) return (ma > mb) ? a : b;
      return (ma < mb) ? a : b;
    end
    if (m[3]) return (ka > kb) ? a : b;
    return (ka < kb) ? a : b;
  endfunction

  task automatic apply(input logic [63:0] a, b, input logic [3:0] m, input logic ie);
    @(negedge clk);
    op_a = a; op_b = b; mode = m; inv_en = ie;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset result", result, 64'd0);
    check("R11 reset flag", {63'd0, snan_flag}, 64'd0);
    check("R11 reset wr_en", {63'd0, wr_en}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].m, 1'b0);
      check($sformatf("vector %0d R%0d", i, VECS[i].req), result, VECS[i].exp);
      check($sformatf("vector %0d R1 flag", i), {63'd0, snan_flag}, {63'd0, VECS[i].flag});
    end

    begin
      logic [63:0] vals [12] = '{PZ, NZ, P1, N1, P2, N2, PI, NI, QN, SN, DN, ND};
      for (int m = 0; m < 16; m++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++) begin
            apply(vals[i], vals[j], 4'(m), 1'b0);
            check($sformatf("sweep m=%0d R3 R4 R5 R6 R7 R8 R9", m), result,
                  model(vals[i], vals[j], 4'(m)));
            check("sweep R1 flag", {63'd0, snan_flag},
                  {63'd0, is_sig(vals[i]) | is_sig(vals[j])});
            check("sweep R10 wr_en", {63'd0, wr_en}, 64'd1);
          end
    end

    // R10 and the NaN rule in the same cycle
    apply(SN, P1, 4'h0, 1'b1);
    check("R10 sNaN a gated", {63'd0, wr_en}, 64'd0);
    check("R3 result kept while gated", result, SQ);
    apply(P1, SN, 4'h8, 1'b1);
    check("R10 sNaN b gated", {63'd0, wr_en}, 64'd0);
    check("R1 flag while gated", {63'd0, snan_flag}, 64'd1);
    apply(QN, P1, 4'h0, 1'b1);
    check("R10 quiet NaN not gated", {63'd0, wr_en}, 64'd1);
    apply(SN, P1, 4'h0, 1'b0);
    check("R10 disabled exception", {63'd0, wr_en}, 64'd1);

    // R11 reset mid-run clears outputs
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again result", result, 64'd0);
    check("R11 reset again wr_en", {63'd0, wr_en}, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog R11: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule